// File: doc/BRIEF.md
# Two-Stage Programmable Timer Prescaler

This block turns one system clock into per-channel clock-enable ticks for a bank of timer channels. Each tick is a one-cycle enable pulse. No derived clock net is ever produced. A channel's tick rate comes from two cascaded dividers. The first is a programmable divide-by-m counter, with m from 1 to 32. The second is a divide-by-2^n stage, with n from 0 to 5, chosen separately for each channel.

Channels fall into three groups:

- **Shared group.** These channels take their first stage from a single common divider. Only one first-stage ratio can be set for the whole group. Each channel in the group still has its own second-stage select.
- **Independent channels.** Each of these owns a private first-stage divider, followed by its own second stage.
- **Single-stage channels.** Each of these owns a private first-stage divider and has no second stage at all.

The ratio and select inputs are plain, level-type control pins, held by a register bank outside this block. The tick outputs are plain pulses with no handshake: a consumer cannot stall them, and a tick that is not used is lost. A ratio field value of k selects division by k+1. A select value of n selects division by 2^n.

Top module: `presc_two_stage`

## Requirements
- R1: While `rst_n` is low, every tick output is 0. Reset clears every first-stage and second-stage counter.
- R2: A first stage with a steady ratio field k produces one tick every k+1 clock cycles. This holds for k from 0 to 31.
- R3: A ratio field of 0 (divide-by-1) produces a first-stage tick on every clock cycle once the value is steady.
- R4: A two-stage channel with ratio field k and select n (n from 0 to 5) ticks once every (k+1)·2^n cycles. Select 0 passes the first-stage tick through unchanged, on the same cycle.
- R5: Select values 6 and 7 act as select 5 (divide by 32 in the second stage).
- R6: All shared-group channels use `grp_ratio`. Group channels with equal selects tick on identical cycles. Any group tick coincides with a tick of a select-0 group channel.
- R7: Each independent channel's first stage follows only its own 5-bit field in `ind_ratio`. Channel i uses bits [5i+4:5i]. Its rate does not depend on the other channels.
- R8: Each single-stage channel uses its own field in `sgl_ratio` (bits [5i+4:5i]) and ticks every k+1 cycles. It has no select input.
- R9: When a ratio field changes, the affected first stage restarts from zero. Count the sampling cycles starting with the one in which the new value is first presented (that cycle is number 1). The first tick of that stage then appears in cycle number k+1.
- R10: A tick is never high on two consecutive cycles unless the channel's total division is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| grp_ratio | input | 5 | First-stage ratio field for the shared group (divide by value+1) |
| grp_sel | input | 3·N_GRP | Second-stage select per group channel; channel i uses bits [3i+2:3i] |
| ind_ratio | input | 5·N_IND | Private first-stage ratio per independent channel |
| ind_sel | input | 3·N_IND | Second-stage select per independent channel |
| sgl_ratio | input | 5·N_SGL | Private first-stage ratio per single-stage channel |
| grp_tick | output | N_GRP | Enable pulses of the shared-group channels |
| ind_tick | output | N_IND | Enable pulses of the independent channels |
| sgl_tick | output | N_SGL | Enable pulses of the single-stage channels |

## Verification
A first-stage counter that holds a wrong value shows up at the ports as a wrong tick spacing. It appears within one first-stage period, at most 32 cycles, and on every channel fed by that stage. A faulty second-stage counter shifts or stretches tick spacing on its own channel only. The fault is visible within (k+1)·32 cycles at most. A stale ratio copy breaks the restart timing. It therefore appears in the first tick after a ratio change, which makes the restart measurement the sharpest single probe.

// File: rtl/presc_pkg.sv
package presc_pkg;
  localparam int unsigned RATIO_W   = 5;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned MAX_SHIFT = 5;

  // effective second-stage shift: out-of-range selects saturate at the top
  function automatic logic [SEL_W-1:0] clamp_shift(input logic [SEL_W-1:0] sel);
    if (sel > SEL_W'(MAX_SHIFT)) return SEL_W'(MAX_SHIFT);
    return sel;
  endfunction
endpackage

// File: rtl/presc_div_m.sv
module presc_div_m #(
  parameter int unsigned RATIO_W = presc_pkg::RATIO_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio,
  output logic               tick
);
  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W-1:0] ratio_q;
  logic               chg;
  logic               hit;

  assign chg  = (ratio != ratio_q);
  assign hit  = (cnt_q == ratio);
  assign tick = rst_n && !chg && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= '0;
    end else begin
      ratio_q <= ratio;
      if (chg || hit) cnt_q <= '0;
      else            cnt_q <= cnt_q + 1'b1;
    end
  end

  // a nonzero ratio can never yield back-to-back ticks
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ratio != '0) |=> !tick);

  // steady divide-by-1 ticks every cycle
  assert_div1_every_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio == '0 && $past(ratio) == '0 && $past(rst_n)) |-> tick);

  // a changed ratio restarts the count from zero
  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio != ratio_q) |=> (cnt_q == '0));
endmodule

// File: rtl/presc_pow2.sv
module presc_pow2 #(
  parameter int unsigned SEL_W     = presc_pkg::SEL_W,
  parameter int unsigned MAX_SHIFT = presc_pkg::MAX_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_tick,
  input  logic [SEL_W-1:0] sel,
  output logic             out_tick
);
  logic [SEL_W-1:0]     eff_n;
  logic [MAX_SHIFT-1:0] mask;
  logic [MAX_SHIFT-1:0] cnt_q;

  assign eff_n = presc_pkg::clamp_shift(sel);

  always_comb begin
    for (int b = 0; b < MAX_SHIFT; b++) mask[b] = (b < int'(eff_n));
  end

  assign out_tick = in_tick && ((cnt_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (in_tick) cnt_q <= cnt_q + 1'b1;
  end

  // with a shift of at least one, a pulse is followed by a quiet cycle
  assert_gap_after_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tick && eff_n != '0) |=> (!out_tick || eff_n != $past(eff_n)));

  assert_only_on_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_tick |-> in_tick);
endmodule

// File: rtl/presc_two_stage.sv
module presc_two_stage #(
  parameter int unsigned N_GRP     = 4,
  parameter int unsigned N_IND     = 2,
  parameter int unsigned N_SGL     = 1,
  parameter int unsigned RATIO_W   = presc_pkg::RATIO_W,
  parameter int unsigned SEL_W     = presc_pkg::SEL_W,
  parameter int unsigned MAX_SHIFT = presc_pkg::MAX_SHIFT
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [RATIO_W-1:0]       grp_ratio,
  input  logic [SEL_W*N_GRP-1:0]   grp_sel,
  input  logic [RATIO_W*N_IND-1:0] ind_ratio,
  input  logic [SEL_W*N_IND-1:0]   ind_sel,
  input  logic [RATIO_W*N_SGL-1:0] sgl_ratio,
  output logic [N_GRP-1:0]         grp_tick,
  output logic [N_IND-1:0]         ind_tick,
  output logic [N_SGL-1:0]         sgl_tick
);
  logic grp_base;

  presc_div_m #(.RATIO_W(RATIO_W)) u_grp_div (
    .clk(clk), .rst_n(rst_n), .ratio(grp_ratio), .tick(grp_base)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    presc_pow2 #(.SEL_W(SEL_W), .MAX_SHIFT(MAX_SHIFT)) u_pow (
      .clk(clk), .rst_n(rst_n), .in_tick(grp_base),
      .sel(grp_sel[g*SEL_W +: SEL_W]), .out_tick(grp_tick[g])
    );

    assert_group_subset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      grp_tick[g] |-> grp_base);

    assert_pass_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_sel[g*SEL_W +: SEL_W] == '0) |-> (grp_tick[g] == grp_base));
  end

  for (genvar c = 0; c < N_IND; c++) begin : g_ind
    logic base;
    presc_div_m #(.RATIO_W(RATIO_W)) u_div (
      .clk(clk), .rst_n(rst_n), .ratio(ind_ratio[c*RATIO_W +: RATIO_W]), .tick(base)
    );
    presc_pow2 #(.SEL_W(SEL_W), .MAX_SHIFT(MAX_SHIFT)) u_pow (
      .clk(clk), .rst_n(rst_n), .in_tick(base),
      .sel(ind_sel[c*SEL_W +: SEL_W]), .out_tick(ind_tick[c])
    );
  end

  for (genvar s = 0; s < N_SGL; s++) begin : g_sgl
    presc_div_m #(.RATIO_W(RATIO_W)) u_div (
      .clk(clk), .rst_n(rst_n), .ratio(sgl_ratio[s*RATIO_W +: RATIO_W]), .tick(sgl_tick[s])
    );
  end

  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    !rst_n |-> (grp_tick == '0 && ind_tick == '0 && sgl_tick == '0));
endmodule

// File: tb/test_presc_two_stage.sv
module test_presc_two_stage;
  localparam time PERIOD = 10ns;
  localparam int  NG = 4, NI = 2, NS = 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [4:0]     grp_ratio = '0;
  logic [3*NG-1:0] grp_sel = '0;
  logic [5*NI-1:0] ind_ratio = '0;
  logic [3*NI-1:0] ind_sel = '0;
  logic [5*NS-1:0] sgl_ratio = '0;
  logic [NG-1:0]  grp_tick;
  logic [NI-1:0]  ind_tick;
  logic [NS-1:0]  sgl_tick;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  presc_two_stage i_presc_two_stage (
    .clk(clk), .rst_n(rst_n), .grp_ratio(grp_ratio), .grp_sel(grp_sel),
    .ind_ratio(ind_ratio), .ind_sel(ind_sel), .sgl_ratio(sgl_ratio),
    .grp_tick(grp_tick), .ind_tick(ind_tick), .sgl_tick(sgl_tick)
  );

  // vector: {ratio field k, select n, expected two-stage period}
  localparam int NV = 10;
  localparam logic [23:0] VEC [NV] = '{
    {5'd0,  3'd0, 16'd1},    {5'd0,  3'd3, 16'd8},
    {5'd3,  3'd0, 16'd4},    {5'd3,  3'd2, 16'd16},
    {5'd4,  3'd5, 16'd160},  {5'd31, 3'd5, 16'd1024},
    {5'd31, 3'd0, 16'd32},   {5'd7,  3'd7, 16'd256},
    {5'd2,  3'd6, 16'd96},   {5'd1,  3'd1, 16'd4}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input int which);
    case (which)
      0: return grp_tick[0];
      1: return ind_tick[0];
      2: return ind_tick[1];
      default: return sgl_tick[0];
    endcase
  endfunction

  // spacing between the second and third ticks seen
  task automatic measure(input int which, output int per);
    int n;
    for (int t = 0; t < 2; t++) begin
      n = 0;
      @(negedge clk);
      while (!pick(which) && n < 4000) begin @(negedge clk); n++; end
    end
    n = 1;
    @(negedge clk);
    while (!pick(which) && n < 4000) begin @(negedge clk); n++; end
    per = n;
  endtask

  initial begin
    #(PERIOD*200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int per;
    int k, n, exp2;
    logic bad;
    // R1: quiet during reset, even with divide-by-1 selected
    grp_ratio = 5'd0; sgl_ratio = '0; ind_ratio = '0;
    bad = 1'b0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (grp_tick != 0 || ind_tick != 0 || sgl_tick != 0) bad = 1'b1;
    end
    check(!bad, "R1 reset ticks", int'(bad), 0);
    @(negedge clk) rst_n = 1'b1;

    // table walk: R2 R3 R4 R5 R8
    for (int v = 0; v < NV; v++) begin
      k    = int'(VEC[v][23:19]);
      n    = int'(VEC[v][18:16]);
      exp2 = int'(VEC[v][15:0]);
      grp_ratio = 5'(k);
      grp_sel   = {NG{3'(n)}};
      ind_ratio = {NI{5'(k)}};
      ind_sel   = {NI{3'(n)}};
      sgl_ratio = {NS{5'(k)}};
      measure(0, per);
      check(per == exp2, "R4/R5 group period", per, exp2);
      measure(1, per);
      check(per == exp2, "R4/R5 independent period", per, exp2);
      measure(3, per);
      check(per == k + 1, "R2/R8 single-stage period", per, k + 1);
    end

    // R3: divide-by-1 ticks on every cycle
    sgl_ratio = '0;
    repeat (3) @(negedge clk);
    bad = 1'b0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (!sgl_tick[0]) bad = 1'b1;
    end
    check(!bad, "R3 divide-by-1 every cycle", int'(bad), 0);

    // R9: restart after a ratio change
    sgl_ratio = 5'd9;
    repeat (25) @(negedge clk);
    sgl_ratio = 5'd4;
    n = 0;
    do begin @(negedge clk); n++; end while (!sgl_tick[0] && n < 100);
    check(n == 5, "R9 first tick after change", n, 5);
    sgl_ratio = 5'd0;
    n = 0;
    do begin @(negedge clk); n++; end while (!sgl_tick[0] && n < 100);
    check(n == 1, "R9 first tick after change to 0", n, 1);

    // R7: private ratios are independent
    ind_ratio = {5'd4, 5'd2};
    ind_sel   = '0;
    measure(1, per);
    check(per == 3, "R7 independent ch0", per, 3);
    measure(2, per);
    check(per == 5, "R7 independent ch1", per, 5);

    // R6 / R10: shared group alignment and pulse width
    grp_ratio = 5'd2;
    grp_sel   = {3'd2, 3'd1, 3'd0, 3'd2};
    repeat (30) @(negedge clk);
    bad = 1'b0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (grp_tick[0] != grp_tick[3]) bad = 1'b1;
      if ((grp_tick[0] || grp_tick[2]) && !grp_tick[1]) bad = 1'b1;
    end
    check(!bad, "R6 group alignment", int'(bad), 0);
    bad = 1'b0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (grp_tick[1]) begin
        @(negedge clk);
        if (grp_tick[1]) bad = 1'b1;
      end
    end
    check(!bad, "R10 no back-to-back ticks", int'(bad), 0);

    // R1: reset mid-run silences ticks
    grp_ratio = 5'd0; grp_sel = '0;
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check(grp_tick == 0 && sgl_tick == 0, "R1 mid-run reset", int'(grp_tick), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule